// File: doc/BRIEF.md
# Serial Audio-Control Register Interface

This block receives 16-bit control words over a three-wire serial link made of a data line, a shift clock and a latch request. It decodes each accepted word into a bank of registered audio-control settings. These settings are the input selector and attenuator codes, the record-input gain, the input and output gain steps, the mute flags, the bass-boost enable, six general-purpose output ports and six 7-bit channel volume codes. The link pins are asynchronous. A fast system clock samples them through two-flop synchronizers and finds their rising edges. The system clock must run at 10 MHz or more, so that a 0.4 µs pin pulse spans several samples.

A word is built from bits shifted in least-significant first, one bit on each shift-clock rise. The word has no effect until the latch-request line rises. Word layout: D0–D2 carry the chip address, D3–D6 carry the format code and D7–D15 carry the payload. A word is committed only when both of these hold: exactly 16 bits were shifted, and the address equals the `CHIP_ADDR` parameter. Any other latch edge discards the word and clears the bit count.

The frame tracker is a state machine with four states:

| State | Meaning |
|---|---|
| IDLE | No bits have been received. |
| SHIFT | 1 to 15 bits have been received. |
| FULL | Exactly 16 bits have been received. |
| OVER | More than 16 bits have been received. |

Its transitions:

| Transition | Condition |
|---|---|
| IDLE→SHIFT | First shift-clock rise. |
| SHIFT→FULL | The shift-clock rise that brings in the 16th bit. |
| FULL→OVER | A further shift-clock rise. |
| Any state→IDLE | Latch rise. It commits the word only when leaving FULL. |

When a latch rise and a shift rise arrive in the same cycle, the latch rise wins.

Top module: `sctl_regbank`

## Requirements
- R1: After reset the outputs hold these values:
  - `in_sel`=7 (muted selector) and `in_att`=1 (-8 dB).
  - `rec_gain`=0 (+1 dB).
  - All other gain codes are 0. This makes the sub output +6 dB.
  - All ports are off and `mute_all`=0.
  - `mic_mute`=1, `rec2_mute`=0 and `bass_boost`=0.
  - Every volume code is 127 (muted).
- R2: Shifting bits without a latch rise never changes any output.
- R3: Bits arrive D0 first on shift-clock rises. The committed values appear within a few cycles of the synchronized latch rise. Volume codes sit in D7–D13, with D7 as the least significant bit.
- R4: A word whose D0–D2 differ from `CHIP_ADDR` is discarded at the latch edge.
- R5: A latch edge after a bit count other than 16 (for example 15 or 17) changes nothing. It also clears the count, so the next 16-bit word commits normally.
- R6: Format 0 writes these fields:
  - `in_sel` from D7–D9.
  - `in_att` from D10–D12. Codes 0..5 are -4.4/-8/-9.4/-11.6/-13/-16.6 dB.
  - `rec_gain` from D13–D14. Codes 0..3 are +1/+3/+4.6/+6.6 dB.
- R7: Format 1 writes these fields:
  - `flfr_in_gain` from D7.
  - `surr_in_gain` from D8.
  - `flfr_out_gain` from D9–D10.
  - `surr_out_gain` from D11.
  - `sub_out_gain` from D12, where 0 is +6 dB and 1 is +10 dB.

  `mic_mix_gain` always equals `flfr_out_gain`. Its codes 0..3 mean 0/-2/-6.5/-10.5 dB.
- R8: Format 2 writes `port_out[5:0]` from D7–D12. Format 3 writes these flags:
  - `mute_all` from D7.
  - `mic_mute` from D8.
  - `rec2_mute` from D9.
  - `bass_boost` from D10.
- R9: Formats 4–9 each write one 7-bit volume code, for channels 0–5 in that order. `vol_code[7*k+6:7*k]` is channel k. No other channel changes.
- R10: A committed volume code from 88 to 126 is stored unchanged and pulses `vol_err` for exactly one cycle. Codes 0–87 and 127 never pulse `vol_err`.
- R11: Formats 10–15 change no output.
- R12: Asserting `rst_n` low synchronously reloads every R1 default at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 10 MHz or faster |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_latch | input | 1 | Latch request (asynchronous) |
| in_sel | output | 3 | Input selector code, 7 = muted |
| in_att | output | 3 | Input attenuator code |
| rec_gain | output | 2 | Record-input gain code |
| flfr_in_gain | output | 1 | Front input gain, 0/+3.6 dB |
| surr_in_gain | output | 1 | Centre/surround/sub input gain, 0/+3.6 dB |
| flfr_out_gain | output | 2 | Front output gain, 0/+2/+6.5/+10.5 dB |
| mic_mix_gain | output | 2 | Microphone mix gain, follows front output gain |
| surr_out_gain | output | 1 | Centre/surround output gain, 0/+6 dB |
| sub_out_gain | output | 1 | Sub output gain, +6/+10 dB |
| port_out | output | 6 | General-purpose output ports |
| mute_all | output | 1 | Global mute |
| mic_mute | output | 1 | Microphone mute |
| rec2_mute | output | 1 | Second record-output mute |
| bass_boost | output | 1 | Bass-boost enable |
| vol_code | output | 42 | Six 7-bit volume codes, channel k in bits 7k+6:7k |
| vol_err | output | 1 | One-cycle pulse on an undefined volume code |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- **Sixteen bits shifted, latch withheld.** A design that updates while shifting shows changed outputs before the latch.
- **Latch after 15 or 17 bits.** A design that commits on any latch, or that does not clear its count, corrupts a register or misaligns the next word.
- **Volume codes 87, 88, 126 and 127.** An off-by-one range check pulses `vol_err` wrongly or misses it.
- **Foreign chip address.** A design without the address check overwrites registers.
- **Unused formats 10–15.** A design without the format check overwrites registers.

Random words, mostly addressed to this chip, are compared with a bench model of the field map. A mid-run reset shows whether all the defaults come back.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_FULL  = 2'd2,
        S_OVER  = 2'd3
    } frame_state_e;

    localparam int SEL_W   = 3;
    localparam int ATT_W   = 3;
    localparam int RECG_W  = 2;
    localparam int OUTG_W  = 2;
    localparam int PORT_N  = 6;

    localparam int FMT_SELECT = 0;
    localparam int FMT_GAIN   = 1;
    localparam int FMT_PORT   = 2;
    localparam int FMT_MUTE   = 3;
    localparam int FMT_VOL0   = 4;

    localparam logic [SEL_W-1:0]  SEL_DEFAULT  = 3'd7;
    localparam logic [ATT_W-1:0]  ATT_DEFAULT  = 3'd1;
    localparam logic [RECG_W-1:0] RECG_DEFAULT = 2'd0;

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
            prev_q <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign rise = dout & ~prev_q;

    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & $past(rise)) == '0);

endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
    import sctl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              shift_rise,
    input  logic              latch_rise,
    output logic [WORD_W-1:0] word,
    output logic              commit
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state: a latch edge always returns to IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (latch_rise) state_d = S_IDLE;
                     else if (shift_rise) state_d = S_SHIFT;
            S_SHIFT: if (latch_rise) state_d = S_IDLE;
                     else if (shift_rise && cnt_q == LAST_IDX) state_d = S_FULL;
            S_FULL:  if (latch_rise) state_d = S_IDLE;
                     else if (shift_rise) state_d = S_OVER;
            S_OVER:  if (latch_rise) state_d = S_IDLE;
        endcase
    end

    // datapath: bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (latch_rise) begin
            cnt_q <= '0;
        end else if (shift_rise && (state_q == S_IDLE || state_q == S_SHIFT)) begin
            word_q[cnt_q[IDX_W-1:0]] <= bit_in;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            S_FULL:  commit = latch_rise;
            default: commit = 1'b0;
        endcase
    end
    assign word = word_q;

    assert_idle_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_IDLE |-> cnt_q == '0);
    assert_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FULL |-> cnt_q == FULL_CNT);
    assert_shift_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_SHIFT |-> (cnt_q != '0 && cnt_q < FULL_CNT));

endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
    import sctl_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              ADDR_W    = 3,
    parameter int              FMT_W     = 4,
    parameter int              NUM_VOL   = 6,
    parameter int              VOL_W     = 7,
    parameter int              VOL_MAX   = 87,
    parameter logic [ADDR_W-1:0] CHIP_ADDR = 3'd5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [WORD_W-1:0]        word,
    output logic [SEL_W-1:0]         in_sel,
    output logic [ATT_W-1:0]         in_att,
    output logic [RECG_W-1:0]        rec_gain,
    output logic                     flfr_in_gain,
    output logic                     surr_in_gain,
    output logic [OUTG_W-1:0]        flfr_out_gain,
    output logic                     surr_out_gain,
    output logic                     sub_out_gain,
    output logic [PORT_N-1:0]        port_out,
    output logic                     mute_all,
    output logic                     mic_mute,
    output logic                     rec2_mute,
    output logic                     bass_boost,
    output logic [NUM_VOL*VOL_W-1:0] vol_flat,
    output logic                     vol_err
);
    localparam int PAY_W  = WORD_W - ADDR_W - FMT_W;
    localparam int VOL_HI = FMT_VOL0 + NUM_VOL - 1;
    localparam logic [VOL_W-1:0] VOL_MUTE = '1;

    logic [ADDR_W-1:0] addr;
    logic [FMT_W-1:0]  fmt;
    logic [PAY_W-1:0]  pay;
    logic              wr;
    logic              vol_fmt;
    logic [VOL_W-1:0]  vol_q [NUM_VOL];

    assign addr    = word[ADDR_W-1:0];
    assign fmt     = word[ADDR_W +: FMT_W];
    assign pay     = word[WORD_W-1 -: PAY_W];
    assign wr      = commit && (addr == CHIP_ADDR);
    assign vol_fmt = (fmt >= FMT_W'(FMT_VOL0)) && (fmt <= FMT_W'(VOL_HI));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sel        <= SEL_DEFAULT;
            in_att        <= ATT_DEFAULT;
            rec_gain      <= RECG_DEFAULT;
            flfr_in_gain  <= 1'b0;
            surr_in_gain  <= 1'b0;
            flfr_out_gain <= '0;
            surr_out_gain <= 1'b0;
            sub_out_gain  <= 1'b0;
            port_out      <= '0;
            mute_all      <= 1'b0;
            mic_mute      <= 1'b1;
            rec2_mute     <= 1'b0;
            bass_boost    <= 1'b0;
        end else if (wr) begin
            if (fmt == FMT_W'(FMT_SELECT)) begin
                in_sel   <= pay[SEL_W-1:0];
                in_att   <= pay[SEL_W +: ATT_W];
                rec_gain <= pay[SEL_W+ATT_W +: RECG_W];
            end
            if (fmt == FMT_W'(FMT_GAIN)) begin
                flfr_in_gain  <= pay[0];
                surr_in_gain  <= pay[1];
                flfr_out_gain <= pay[2 +: OUTG_W];
                surr_out_gain <= pay[2+OUTG_W];
                sub_out_gain  <= pay[3+OUTG_W];
            end
            if (fmt == FMT_W'(FMT_PORT)) port_out <= pay[PORT_N-1:0];
            if (fmt == FMT_W'(FMT_MUTE)) begin
                mute_all   <= pay[0];
                mic_mute   <= pay[1];
                rec2_mute  <= pay[2];
                bass_boost <= pay[3];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_VOL; g++) begin : g_vol
            always_ff @(posedge clk) begin
                if (!rst_n) vol_q[g] <= VOL_MUTE;
                else if (wr && fmt == FMT_W'(FMT_VOL0 + g)) vol_q[g] <= pay[VOL_W-1:0];
            end
            assign vol_flat[g*VOL_W +: VOL_W] = vol_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) vol_err <= 1'b0;
        else vol_err <= wr && vol_fmt && (pay[VOL_W-1:0] > VOL_W'(VOL_MAX))
                        && (pay[VOL_W-1:0] != VOL_MUTE);
    end

    assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(vol_flat) && $stable(port_out) && $stable(in_sel)
                    && $stable(in_att) && $stable(rec_gain) && $stable(flfr_out_gain)
                    && $stable(mic_mute) && $stable(mute_all));
    assert_foreign_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (word[ADDR_W-1:0] != CHIP_ADDR) |=> $stable(vol_flat) && $stable(port_out)
                    && $stable(in_sel) && $stable(mic_mute));
    assert_err_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vol_err |-> $past(commit));
    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vol_err |=> !vol_err);
    assert_unused_fmt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (word[ADDR_W +: FMT_W] > FMT_W'(VOL_HI)) |=> $stable(vol_flat)
                    && $stable(port_out) && $stable(in_sel) && $stable(bass_boost));
    assert_reset_defaults_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (vol_flat == '1) && (in_sel == SEL_DEFAULT) && mic_mute
                    && (port_out == '0));

endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
    import sctl_pkg::*;
#(
    parameter int              WORD_W      = 16,
    parameter int              ADDR_W      = 3,
    parameter int              FMT_W       = 4,
    parameter int              NUM_VOL     = 6,
    parameter int              VOL_W       = 7,
    parameter int              VOL_MAX     = 87,
    parameter int              SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CHIP_ADDR = 3'd5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_data,
    input  logic                     ser_clk,
    input  logic                     ser_latch,
    output logic [2:0]               in_sel,
    output logic [2:0]               in_att,
    output logic [1:0]               rec_gain,
    output logic                     flfr_in_gain,
    output logic                     surr_in_gain,
    output logic [1:0]               flfr_out_gain,
    output logic [1:0]               mic_mix_gain,
    output logic                     surr_out_gain,
    output logic                     sub_out_gain,
    output logic [5:0]               port_out,
    output logic                     mute_all,
    output logic                     mic_mute,
    output logic                     rec2_mute,
    output logic                     bass_boost,
    output logic [NUM_VOL*VOL_W-1:0] vol_code,
    output logic                     vol_err
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0]  pins_s, pins_rise;
    logic [WORD_W-1:0] word;
    logic              commit;

    sctl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_latch, ser_clk, ser_data}),
        .dout  (pins_s),
        .rise  (pins_rise)
    );

    sctl_frame #(.WORD_W(WORD_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (pins_s[0]),
        .shift_rise (pins_rise[1]),
        .latch_rise (pins_rise[2]),
        .word       (word),
        .commit     (commit)
    );

    sctl_decode #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .FMT_W(FMT_W), .NUM_VOL(NUM_VOL),
        .VOL_W(VOL_W), .VOL_MAX(VOL_MAX), .CHIP_ADDR(CHIP_ADDR)
    ) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit        (commit),
        .word          (word),
        .in_sel        (in_sel),
        .in_att        (in_att),
        .rec_gain      (rec_gain),
        .flfr_in_gain  (flfr_in_gain),
        .surr_in_gain  (surr_in_gain),
        .flfr_out_gain (flfr_out_gain),
        .surr_out_gain (surr_out_gain),
        .sub_out_gain  (sub_out_gain),
        .port_out      (port_out),
        .mute_all      (mute_all),
        .mic_mute      (mic_mute),
        .rec2_mute     (rec2_mute),
        .bass_boost    (bass_boost),
        .vol_flat      (vol_code),
        .vol_err       (vol_err)
    );

    // mixing gain tracks the front output gain code one-for-one (R7)
    assign mic_mix_gain = flfr_out_gain;

endmodule

// File: tb/sctl_regbank_tb.sv
module sctl_regbank_tb;
    localparam int PH = 4;
    localparam logic [2:0] MY_ADDR = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
    logic [2:0] in_sel, in_att;
    logic [1:0] rec_gain, flfr_out_gain, mic_mix_gain;
    logic flfr_in_gain, surr_in_gain, surr_out_gain, sub_out_gain;
    logic [5:0] port_out;
    logic mute_all, mic_mute, rec2_mute, bass_boost, vol_err;
    logic [41:0] vol_code;

    always #2 clk = ~clk;

    sctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_latch(ser_latch), .in_sel(in_sel), .in_att(in_att), .rec_gain(rec_gain),
        .flfr_in_gain(flfr_in_gain), .surr_in_gain(surr_in_gain),
        .flfr_out_gain(flfr_out_gain), .mic_mix_gain(mic_mix_gain),
        .surr_out_gain(surr_out_gain), .sub_out_gain(sub_out_gain),
        .port_out(port_out), .mute_all(mute_all), .mic_mute(mic_mute),
        .rec2_mute(rec2_mute), .bass_boost(bass_boost), .vol_code(vol_code),
        .vol_err(vol_err)
    );

    int checks = 0, fails = 0, err_pulses = 0, exp_errs = 0, cycles = 0;
    bit done = 0;

    // expected model
    logic [2:0] e_sel, e_att;
    logic [1:0] e_rec, e_fout;
    logic e_fin, e_sin, e_sout, e_sub, e_mall, e_mic, e_rec2, e_bass;
    logic [5:0] e_port;
    logic [6:0] e_vol [6];

    always @(posedge clk) begin
        cycles++;
        if (rst_n && vol_err) err_pulses++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic model_reset();
        e_sel = 3'd7; e_att = 3'd1; e_rec = 2'd0; e_fout = 2'd0;
        e_fin = 0; e_sin = 0; e_sout = 0; e_sub = 0;
        e_port = '0; e_mall = 0; e_mic = 1; e_rec2 = 0; e_bass = 0;
        for (int k = 0; k < 6; k++) e_vol[k] = 7'h7F;
    endtask

    function automatic logic [15:0] mk(logic [2:0] a, logic [3:0] f, logic [8:0] p);
        return {p, f, a};
    endfunction

    task automatic model_apply(logic [15:0] w);
        logic [8:0] p;
        p = w[15:7];
        if (w[2:0] != MY_ADDR) return;
        case (w[6:3])
            4'd0: begin e_sel = p[2:0]; e_att = p[5:3]; e_rec = p[7:6]; end
            4'd1: begin e_fin = p[0]; e_sin = p[1]; e_fout = p[3:2]; e_sout = p[4]; e_sub = p[5]; end
            4'd2: e_port = p[5:0];
            4'd3: begin e_mall = p[0]; e_mic = p[1]; e_rec2 = p[2]; e_bass = p[3]; end
            4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
                e_vol[w[6:3] - 4] = p[6:0];
                if (p[6:0] > 7'd87 && p[6:0] != 7'h7F) exp_errs++;
            end
            default: ;
        endcase
    endtask

    function automatic logic [67:0] exp_vec();
        logic [41:0] v;
        for (int k = 0; k < 6; k++) v[k*7 +: 7] = e_vol[k];
        return {e_sel, e_att, e_rec, e_fin, e_sin, e_fout, e_fout, e_sout, e_sub,
                e_port, e_mall, e_mic, e_rec2, e_bass, v};
    endfunction

    function automatic logic [67:0] act_vec();
        return {in_sel, in_att, rec_gain, flfr_in_gain, surr_in_gain, flfr_out_gain,
                mic_mix_gain, surr_out_gain, sub_out_gain, port_out, mute_all,
                mic_mute, rec2_mute, bass_boost, vol_code};
    endfunction

    task automatic check_all(string tag);
        checks++;
        if (act_vec() !== exp_vec()) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act_vec(), exp_vec());
        end
    endtask

    task automatic check_errs(string tag);
        checks++;
        if (err_pulses != exp_errs) begin
            fails++;
            $display("FAIL %s: actual %0d error pulses expected %0d", tag, err_pulses, exp_errs);
        end
    endtask

    task automatic shift_bits(logic [31:0] w, int n);
        for (int i = 0; i < n; i++) begin
            ser_data = w[i];
            repeat (PH) @(negedge clk);
            ser_clk = 1'b1;
            repeat (PH) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (PH) @(negedge clk);
    endtask

    task automatic latch();
        ser_latch = 1'b1;
        repeat (PH) @(negedge clk);
        ser_latch = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send(logic [15:0] w);
        shift_bits({16'h0, w}, 16);
        latch();
        model_apply(w);
    endtask

    initial begin
        logic [15:0] w;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 reset defaults");

        // R2: 16 bits shifted, no latch yet
        w = mk(MY_ADDR, 4'd4, 9'd23);
        shift_bits({16'h0, w}, 16);
        repeat (10) @(negedge clk);
        check_all("R2 no change before latch");
        latch();
        model_apply(w);
        check_all("R3 volume ch0 after latch, D7 lsb");

        send(mk(MY_ADDR, 4'd0, {1'b0, 2'd2, 3'd4, 3'd3}));
        check_all("R6 selector/att/rec gain");
        send(mk(MY_ADDR, 4'd1, 9'b000_1_0_11_0_1));
        check_all("R7 gains and mic mix follow");
        send(mk(MY_ADDR, 4'd1, 9'b000_0_1_10_1_0));
        check_all("R7 gains second pattern");
        send(mk(MY_ADDR, 4'd2, 9'b000_101101));
        check_all("R8 ports");
        send(mk(MY_ADDR, 4'd3, 9'b00000_1101));
        check_all("R8 mute and bass flags");
        for (int k = 0; k < 6; k++) begin
            send(mk(MY_ADDR, 4'(4 + k), 9'(10 * k + 1)));
            check_all("R9 single channel volume");
        end

        // R10 boundaries
        send(mk(MY_ADDR, 4'd5, 9'd87));  check_errs("R10 code 87 no error");
        send(mk(MY_ADDR, 4'd5, 9'd88));  check_errs("R10 code 88 error");
        check_all("R10 code 88 stored");
        send(mk(MY_ADDR, 4'd6, 9'd126)); check_errs("R10 code 126 error");
        send(mk(MY_ADDR, 4'd6, 9'd127)); check_errs("R10 code 127 no error");
        send(mk(MY_ADDR, 4'd7, 9'd0));   check_errs("R10 code 0 no error");
        check_all("R10 stored codes");

        // R4 foreign address
        send(mk(3'd2, 4'd2, 9'h3F));
        send(mk(3'd4, 4'd8, 9'd3));
        check_all("R4 foreign address discarded");

        // R5 wrong counts
        shift_bits({16'h0, mk(MY_ADDR, 4'd2, 9'h15)}, 15);
        latch();
        check_all("R5 15-bit word ignored");
        shift_bits({15'h0, 1'b1, mk(MY_ADDR, 4'd2, 9'h2A)}, 17);
        latch();
        check_all("R5 17-bit word ignored");
        send(mk(MY_ADDR, 4'd2, 9'h0C));
        check_all("R5 count cleared, next word commits");

        // R11 unused formats
        for (int f = 10; f < 16; f++) send(mk(MY_ADDR, 4'(f), 9'h1FF));
        check_all("R11 unused formats no effect");

        // random words
        for (int n = 0; n < 60; n++) begin
            logic [2:0] a;
            a = ($urandom % 4 == 0) ? 3'($urandom) : MY_ADDR;
            send(mk(a, 4'($urandom % 12), 9'($urandom)));
            check_all("R3 R6 R7 R8 R9 random word");
        end
        check_errs("R10 random error pulse total");

        // R12 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        check_all("R12 reset reloads defaults");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule